// File: doc/BRIEF.md
# Serial-Loaded Latched LED Channel Controller

This block is the digital core of a low-side LED switch with `NUM_CH` channels (ten by default). A host shifts one bit per rising edge of a serial clock into a shift register of exactly `NUM_CH` stages. The bit shifted most recently sits in stage 0 and sets channel 0. Older bits move toward the highest channel. The last stage drives a serial output, so several devices can be chained to one data line.

A level-sensitive transfer input controls what the channels show. While it is high, the register contents pass straight through to the channel enables. While it is low, the enables keep the last value that passed through. Two inputs override every channel and force it off: an active-high blanking input, and an over-voltage flag from a battery monitor. Both act without any clock. Neither changes the stored data, so the channels return to their stored pattern as soon as both inputs go low.

The serial clock, data and transfer inputs are sampled by a fast system clock through a synchronizer. A supply-good input works as an asynchronous active-low reset. It clears the register and the held channel states.

Top module: `led_serial_ctrl`

## Requirements
- R1: The shift register has exactly `NUM_CH` stages. Each rising edge of `ser_clk` moves every stored bit up by one stage and loads `ser_din` into stage 0. No other activity changes the register.
- R2: After a transfer, `ch_en[k]` (bit k = channel k, 1 = switch on) equals the bit that was shifted in k rising edges before the most recent one. The most recent bit sets `ch_en[0]`.
- R3: `ser_dout` carries the last stage. This is the same bit that sets channel `NUM_CH-1` on a transfer, and it changes only after a rising edge of `ser_clk`.
- R4: While `xfer` is low, `ch_en` keeps its value no matter how many bits are shifted in.
- R5: While `xfer` is high, `ch_en` follows the register. A bit shifted in during that time appears on the channels without a new transfer pulse.
- R6: While `blank` is high, every bit of `ch_en` is 0 with no clock edge needed. When `blank` returns low, the stored pattern comes back unchanged.
- R7: While `ovp_flag` is high, every bit of `ch_en` is 0 with no clock edge needed. When it clears, the stored pattern comes back without a reload.
- R8: While `supply_good` is low, the register and the held channel states are zero, so `ser_dout` and `ch_en` are 0. After reset is released, `ser_dout` stays 0 until `NUM_CH` bits have been shifted in.
- R9: With two devices chained (`ser_dout` of the first drives `ser_din` of the second), shifting 2·`NUM_CH` bits and then pulsing `xfer` puts the first `NUM_CH` bits in the second device and the last `NUM_CH` bits in the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| supply_good | input | 1 | Supply-good indication; low holds the logic in reset (asynchronous) |
| ser_clk | input | 1 | Serial shift clock; data moves on its rising edge |
| ser_din | input | 1 | Serial data into stage 0 |
| xfer | input | 1 | Transfer control; high = transparent, low = hold |
| blank | input | 1 | Active-high blanking of all channels |
| ovp_flag | input | 1 | Over-voltage condition; high turns all channels off |
| ser_dout | output | 1 | Last register stage, for chaining |
| ch_en | output | NUM_CH | Channel switch enables, bit k = channel k, 1 = on |

## Verification
The bench uses the default build of ten channels with a two-stage synchronizer, and it chains two instances. This makes the full twenty-bit load reachable, and it shows exactly where the ten-bit boundary falls between the upstream and the downstream device. Because `NUM_CH` is ten, the bench can also count the nine shifts during which `ser_dout` must stay low after reset, and then the tenth shift that first brings a one out.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int LSC_CH_DEFAULT   = 10;
  localparam int LSC_SYNC_DEFAULT = 2;

  // Raw serial-side inputs, carried together through the synchronizer
  typedef struct packed {
    logic sck;
    logic sdi;
    logic xfr;
  } lsc_ser_t;

  // Rising-edge detection on a sampled level
  function automatic logic lsc_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Channel enable: a stored one, unless blanking or over-voltage is active
  function automatic logic lsc_gate(input logic lat_v, input logic blank_v,
                                    input logic ovp_v);
    return lat_v & ~blank_v & ~ovp_v;
  endfunction

endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/lsc_shifter.sv
module lsc_shifter #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [N-1:0] bits,
  output logic         dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bits <= '0;
    else if (step) bits <= {bits[N-2:0], din};
  end

  assign dout = bits[N-1];

  // R1: one stage per step, new bit enters at stage 0
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> bits[N-1:1] == $past(bits[N-2:0]));
  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> bits[0] == $past(din));
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(bits));

  // R8: register empty while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_clear: assert (bits == '0);
    end
  end

endmodule

// File: rtl/lsc_hold.sv
module lsc_hold #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [N-1:0] d,
  output logic [N-1:0] view
);

  logic [N-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (open) hold_q <= d;
  end

  // Transparent while open, otherwise the last captured value
  assign view = open ? d : hold_q;

  // R4: closed transfer keeps the held state
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(hold_q));
  // R5: open transfer tracks the register
  a_r5_track: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> hold_q == $past(d));

endmodule

// File: rtl/led_serial_ctrl.sv
module led_serial_ctrl
  import lsc_pkg::*;
#(
  parameter int NUM_CH      = LSC_CH_DEFAULT,
  parameter int SYNC_STAGES = LSC_SYNC_DEFAULT
) (
  input  logic              clk,
  input  logic              supply_good,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              xfer,
  input  logic              blank,
  input  logic              ovp_flag,
  output logic              ser_dout,
  output logic [NUM_CH-1:0] ch_en
);

  localparam int SER_W = $bits(lsc_ser_t);

  logic              rst_n;
  lsc_ser_t          raw_s;
  lsc_ser_t          sync_s;
  logic              sck_prev;
  logic              step;
  logic [NUM_CH-1:0] reg_bits;
  logic [NUM_CH-1:0] view_bits;

  assign rst_n = supply_good;
  assign raw_s = '{sck: ser_clk, sdi: ser_din, xfr: xfer};

  lsc_sync #(.W(SER_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_s),
    .d_out (sync_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sync_s.sck;
  end

  assign step = lsc_rise(sync_s.sck, sck_prev);

  lsc_shifter #(.N(NUM_CH)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .din   (sync_s.sdi),
    .bits  (reg_bits),
    .dout  (ser_dout)
  );

  lsc_hold #(.N(NUM_CH)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .open  (sync_s.xfr),
    .d     (reg_bits),
    .view  (view_bits)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_en[i] = lsc_gate(view_bits[i], blank, ovp_flag);
  end

  // R3: serial output is the bit that was one stage below before the step
  a_r3_dout: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ser_dout == $past(reg_bits[NUM_CH-2]));

  // R6 / R7: overrides force every channel off at once
  always_comb begin
    if (blank) begin
      a_r6_blank_off: assert (ch_en == '0);
    end
    if (ovp_flag) begin
      a_r7_ovp_off: assert (ch_en == '0);
    end
  end

endmodule

// File: tb/test_led_serial_ctrl.sv
module test_led_serial_ctrl;

  localparam int N = 10;

  logic clk = 1'b0;
  logic supply_good = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic xfer = 1'b0;
  logic blank = 1'b0;
  logic ovp_flag = 1'b0;
  logic up_dout, dn_dout;
  logic [N-1:0] up_en, dn_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2*N-1:0] model = '0;   // model[k] = bit shifted k edges ago
  logic [N-1:0] held_up = '0;
  logic [N-1:0] held_dn = '0;

  always #2.5 clk = ~clk;

  led_serial_ctrl i_led_serial_ctrl (
    .clk(clk), .supply_good(supply_good), .ser_clk(ser_clk),
    .ser_din(ser_din), .xfer(xfer), .blank(blank), .ovp_flag(ovp_flag),
    .ser_dout(up_dout), .ch_en(up_en)
  );

  led_serial_ctrl i_led_serial_ctrl_dn (
    .clk(clk), .supply_good(supply_good), .ser_clk(ser_clk),
    .ser_din(up_dout), .xfer(xfer), .blank(blank), .ovp_flag(ovp_flag),
    .ser_dout(dn_dout), .ch_en(dn_en)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (5) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    model = {model[2*N-2:0], b};
  endtask

  task automatic pulse_xfer();
    xfer = 1'b1;
    repeat (5) @(negedge clk);
    xfer = 1'b0;
    repeat (5) @(negedge clk);
    held_up = model[N-1:0];
    held_dn = model[2*N-1:N];
  endtask

  task automatic t_reset();
    #2 supply_good = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset up ch_en", 32'(up_en), 32'h0);
    check("R8 reset dn ch_en", 32'(dn_en), 32'h0);
    check("R8 reset dout", 32'(up_dout), 32'h0);
    supply_good = 1'b1;
    repeat (3) @(negedge clk);
    model = '0;
  endtask

  task automatic t_fill();
    for (int k = 0; k < N; k++) begin
      shift_bit(1'b1);
      // R3: zero until the tenth bit reaches the last stage (R1 length)
      check(k == N-1 ? "R1 R3 tenth bit at dout" : "R8 R3 dout zero while filling",
            32'(up_dout), 32'(model[N-1]));
    end
  endtask

  task automatic t_chain(input logic [2*N-1:0] pat, input string tag);
    for (int k = 2*N-1; k >= 0; k--) shift_bit(pat[k]);
    pulse_xfer();
    check({"R2 upstream ", tag}, 32'(up_en), 32'(model[N-1:0]));
    check({"R9 downstream ", tag}, 32'(dn_en), 32'(model[2*N-1:N]));
    check({"R9 first bits downstream ", tag}, 32'(dn_en), 32'(pat[2*N-1:N]));
  endtask

  task automatic t_hold();
    for (int k = 0; k < 2*N; k++) shift_bit(k[0] ^ k[2]);
    check("R4 up held", 32'(up_en), 32'(held_up));
    check("R4 dn held", 32'(dn_en), 32'(held_dn));
    pulse_xfer();
    check("R4 up after pulse", 32'(up_en), 32'(model[N-1:0]));
  endtask

  task automatic t_transparent();
    xfer = 1'b1;
    repeat (5) @(negedge clk);
    shift_bit(~model[0]);
    check("R5 up follows", 32'(up_en), 32'(model[N-1:0]));
    check("R5 dn follows", 32'(dn_en), 32'(model[2*N-1:N]));
    xfer = 1'b0;
    repeat (5) @(negedge clk);
    held_up = model[N-1:0];
    held_dn = model[2*N-1:N];
  endtask

  task automatic t_override(input bit use_ovp, input string req);
    if (use_ovp) ovp_flag = 1'b1; else blank = 1'b1;
    #1;
    check({req, " up off"}, 32'(up_en), 32'h0);
    check({req, " dn off"}, 32'(dn_en), 32'h0);
    repeat (4) @(negedge clk);
    ovp_flag = 1'b0;
    blank = 1'b0;
    #1;
    check({req, " up restored"}, 32'(up_en), 32'(held_up));
    check({req, " dn restored"}, 32'(dn_en), 32'(held_dn));
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    supply_good = 1'b0;
    #1;
    check("R8 mid reset ch_en", 32'(up_en), 32'h0);
    check("R8 mid reset dout", 32'(up_dout), 32'h0);
    @(negedge clk);
    supply_good = 1'b1;
    repeat (3) @(negedge clk);
    model = '0;
    held_up = '0;
    held_dn = '0;
    pulse_xfer();
    check("R8 register cleared", 32'(up_en), 32'h0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_chain(20'hA5C31, "pattern A");
    t_chain(20'h0F3E6, "pattern B");
    t_hold();
    t_transparent();
    t_override(1'b0, "R6 blank");
    t_override(1'b1, "R7 ovp");
    t_reset_mid();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule